// File: doc/BRIEF.md
# Packet Write-Commit Queue

This block sits beside the register file of a wide-issue core that executes instructions in packets. The instructions of one packet do not change architectural state while they run. Each one posts its register writes and control-flow writes into this queue, tagged with the address of the instruction that posted them. When the packet ends, a commit pulse drains the queue in posting order, one entry per clock. Each entry drives a single register write port or updates the visible program counter.

During the drain, a recorded imprecise exception decides which writes of the faulting instruction survive. Only the first surviving control-flow write becomes the packet's branch target. An optional link update writes the address of the next sequential packet into the link register. A clear pulse starts a new packet. It empties the queue, forgets the exception and link state, and keeps the visible PC as the previous-packet PC.

Top module: `pkt_commit_queue`

## Requirements
- R1: After a commit pulse is accepted, the k-th queued entry (counting from 0) is acted on at the (k+2)-th rising edge. One edge after the last entry, `done_o` pulses for one cycle, `busy_o` falls and the queue is empty. An empty queue gives `done_o` at the second edge.
- R2: Only the first control-flow entry that survives filtering sets the branch target, whether it is a plain or a function PC write. Later control-flow entries in the same drain change nothing.
- R3: Exception filtering applies only to entries whose issuing address equals the recorded faulting address. All other entries are applied normally.
- R4: For a recorded floating-point exception, the faulting instruction's entries are applied only if the status mask has no bit set outside `BENIGN_MASK`. The default is bits 0 to 2: inexact, underflow and overflow.
- R5: For a recorded non-floating-point exception, a faulting instruction's entry is applied only when its force flag is 1.
- R6: When an entry is applied, `pc_o` takes that entry's issuing address on the same edge. When the drain ends, `pc_o` takes the branch target if one was taken. Otherwise it takes `seq_pc_i` as sampled at the commit pulse.
- R7: If `link_set_i` was seen since the last clear or drain, `lr_we_o` pulses together with `done_o`, with `lr_data_o` equal to the sampled `seq_pc_i`. The link flag is then cleared.
- R8: `clear_i` empties the queue, clears the exception record, the link flag and the overflow flag, and copies `pc_o` into `prev_pc_o`.
- R9: An enqueue made while `DEPTH` entries are already held is dropped and sets the sticky flag `ovf_o`.
- R10: The kind encoding is 0 for a register write (on `rf_we_o`/`rf_idx_o`/`rf_data_o`), 1 for a plain PC write and 2 for a function PC write. Kind 3 is reserved: such an entry causes no write and no PC change.
- R11: While `busy_o` is high, the enqueue, clear, commit, link and exception inputs are ignored. In an idle cycle, clear has priority over commit, and commit has priority over enqueue.
- R12: After reset, `busy_o`, `done_o`, `ovf_o`, `rf_we_o` and `lr_we_o` are 0, and `pc_o` and `prev_pc_o` hold `RESET_PC`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid_i | input | 1 | Post one entry |
| enq_kind_i | input | 2 | Entry kind (R10 encoding) |
| enq_idx_i | input | IW | Target register index |
| enq_data_i | input | DW | Register value or PC target |
| enq_iaddr_i | input | AW | Address of the posting instruction |
| enq_force_i | input | 1 | Write survives a non-FP exception |
| exc_set_i | input | 1 | Record an imprecise exception |
| exc_fp_i | input | 1 | Recorded exception is floating-point |
| exc_mask_i | input | MW | Floating-point status mask |
| exc_iaddr_i | input | AW | Faulting instruction address |
| link_set_i | input | 1 | Request a link-register update |
| seq_pc_i | input | AW | Next sequential packet address |
| commit_i | input | 1 | Start draining the queue |
| clear_i | input | 1 | Start a new packet |
| rf_we_o | output | 1 | Register write strobe |
| rf_idx_o | output | IW | Register write index |
| rf_data_o | output | DW | Register write value |
| lr_we_o | output | 1 | Link register write strobe |
| lr_data_o | output | AW | Link register value |
| pc_o | output | AW | Visible program counter |
| prev_pc_o | output | AW | PC kept at the last clear |
| busy_o | output | 1 | Drain in progress |
| done_o | output | 1 | Drain finished (one cycle) |
| ovf_o | output | 1 | Sticky overflow |

## Verification
The bench uses the default parameters: a depth of 8, 32-bit data and addresses, and an 8-bit mask with a benign set of bits 0 to 2. A depth of 8 is small enough that one table packet fills the queue exactly and a ninth post reaches the overflow path. The same packet also contains both a filtered branch and a second, discarded branch. Directed packets cover a benign and a harmful floating-point mask, a reserved kind, the link update and its one-shot clearing, posts made while busy, and a clear that discards posted entries.

// File: rtl/pcq_pkg.sv
package pcq_pkg;
  typedef enum logic [1:0] {
    K_REG  = 2'd0,
    K_PC   = 2'd1,
    K_FNPC = 2'd2,
    K_RSV  = 2'd3
  } kind_e;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } state_e;
endpackage

// File: rtl/pcq_store.sv
module pcq_store #(
  parameter int DEPTH = 8,
  parameter int IW    = 5,
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [1:0]    push_kind_i,
  input  logic [IW-1:0] push_idx_i,
  input  logic [DW-1:0] push_data_i,
  input  logic [AW-1:0] push_iaddr_i,
  input  logic          push_force_i,
  input  logic [CW-1:0] rd_ptr_i,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic [1:0]    rd_kind_o,
  output logic [IW-1:0] rd_idx_o,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] rd_iaddr_o,
  output logic          rd_force_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] count_q;
  logic [1:0]    kind_q  [DEPTH];
  logic [IW-1:0] idx_q   [DEPTH];
  logic [DW-1:0] data_q  [DEPTH];
  logic [AW-1:0] iaddr_q [DEPTH];
  logic          force_q [DEPTH];
  logic [DEPTH-1:0] hit;
  logic [PW-1:0] wr_sel;

  assign wr_sel  = count_q[PW-1:0];
  assign count_o = count_q;
  assign full_o  = (count_q == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clr_i) begin
      count_q <= '0;
    end else if (push_i) begin
      count_q <= count_q + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !clr_i) begin
      kind_q[wr_sel]  <= push_kind_i;
      idx_q[wr_sel]   <= push_idx_i;
      data_q[wr_sel]  <= push_data_i;
      iaddr_q[wr_sel] <= push_iaddr_i;
      force_q[wr_sel] <= push_force_i;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_hit
    assign hit[s] = (rd_ptr_i == CW'(s));
  end

  always_comb begin
    rd_kind_o  = '0;
    rd_idx_o   = '0;
    rd_data_o  = '0;
    rd_iaddr_o = '0;
    rd_force_o = 1'b0;
    for (int s = 0; s < DEPTH; s++) begin
      if (hit[s]) begin
        rd_kind_o  = kind_q[s];
        rd_idx_o   = idx_q[s];
        rd_data_o  = data_q[s];
        rd_iaddr_o = iaddr_q[s];
        rd_force_o = force_q[s];
      end
    end
  end

  // R9
  push_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i) |=> (count_o == $past(count_o) + CW'(1)));
endmodule

// File: rtl/pcq_filter.sv
module pcq_filter #(
  parameter int AW = 32,
  parameter int MW = 8,
  parameter logic [MW-1:0] BENIGN_MASK = 8'h07
) (
  input  logic [1:0]    kind_i,
  input  logic [AW-1:0] iaddr_i,
  input  logic          force_i,
  input  logic          exc_valid_i,
  input  logic          exc_fp_i,
  input  logic [MW-1:0] exc_mask_i,
  input  logic [AW-1:0] exc_iaddr_i,
  input  logic          br_taken_i,
  output logic          apply_o,
  output logic          apply_reg_o,
  output logic          apply_pc_o
);
  import pcq_pkg::*;

  function automatic logic exc_allows(input logic fp, input logic [MW-1:0] mask,
                                      input logic frc);
    if (fp) return ((mask & ~BENIGN_MASK) == '0);
    return frc;
  endfunction

  logic hit_fault, passes, is_pc;

  assign hit_fault = exc_valid_i && (iaddr_i == exc_iaddr_i);
  assign passes    = !hit_fault || exc_allows(exc_fp_i, exc_mask_i, force_i);
  assign is_pc     = (kind_i == K_PC) || (kind_i == K_FNPC);

  assign apply_o     = passes && (kind_i != K_RSV) && !(is_pc && br_taken_i);
  assign apply_reg_o = apply_o && (kind_i == K_REG);
  assign apply_pc_o  = apply_o && is_pc;
endmodule

// File: rtl/pkt_commit_queue.sv
module pkt_commit_queue #(
  parameter int DEPTH = 8,
  parameter int IW    = 5,
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int MW    = 8,
  parameter logic [MW-1:0] BENIGN_MASK = 8'h07,
  parameter logic [AW-1:0] RESET_PC    = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_valid_i,
  input  logic [1:0]    enq_kind_i,
  input  logic [IW-1:0] enq_idx_i,
  input  logic [DW-1:0] enq_data_i,
  input  logic [AW-1:0] enq_iaddr_i,
  input  logic          enq_force_i,
  input  logic          exc_set_i,
  input  logic          exc_fp_i,
  input  logic [MW-1:0] exc_mask_i,
  input  logic [AW-1:0] exc_iaddr_i,
  input  logic          link_set_i,
  input  logic [AW-1:0] seq_pc_i,
  input  logic          commit_i,
  input  logic          clear_i,
  output logic          rf_we_o,
  output logic [IW-1:0] rf_idx_o,
  output logic [DW-1:0] rf_data_o,
  output logic          lr_we_o,
  output logic [AW-1:0] lr_data_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] prev_pc_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ovf_o
);
  import pcq_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);

  state_e        state_q;
  logic [CW-1:0] rd_ptr_q;
  logic          br_taken_q, link_q, ovf_q;
  logic [AW-1:0] new_pc_q, save_pc_q, pc_q, prev_pc_q;
  logic          exc_valid_q, exc_fp_q;
  logic [MW-1:0] exc_mask_q;
  logic [AW-1:0] exc_iaddr_q;
  logic          rf_we_q, done_q, lr_we_q;
  logic [IW-1:0] rf_idx_q;
  logic [DW-1:0] rf_data_q;
  logic [AW-1:0] lr_data_q;
  logic [1:0]    pc_apply_cnt;

  // named internal events
  logic idle, clr_go, cmt_go, enq_try, push, push_drop, step, final_step;
  logic exc_go, link_go;
  logic [CW-1:0] count;
  logic          full;
  logic [1:0]    rd_kind;
  logic [IW-1:0] rd_idx;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] rd_iaddr;
  logic          rd_force;
  logic          flt_apply, flt_apply_reg, flt_apply_pc;

  assign idle       = (state_q == S_IDLE);
  assign clr_go     = idle && clear_i;
  assign cmt_go     = idle && commit_i && !clear_i;
  assign enq_try    = idle && enq_valid_i && !clear_i && !commit_i;
  assign push       = enq_try && !full;
  assign push_drop  = enq_try && full;
  assign exc_go     = idle && exc_set_i && !clear_i;
  assign link_go    = idle && link_set_i && !clear_i;
  assign step       = (state_q == S_RUN) && (rd_ptr_q != count);
  assign final_step = (state_q == S_RUN) && (rd_ptr_q == count);

  pcq_store #(.DEPTH(DEPTH), .IW(IW), .DW(DW), .AW(AW), .CW(CW)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (clr_go || final_step),
    .push_i       (push),
    .push_kind_i  (enq_kind_i),
    .push_idx_i   (enq_idx_i),
    .push_data_i  (enq_data_i),
    .push_iaddr_i (enq_iaddr_i),
    .push_force_i (enq_force_i),
    .rd_ptr_i     (rd_ptr_q),
    .count_o      (count),
    .full_o       (full),
    .rd_kind_o    (rd_kind),
    .rd_idx_o     (rd_idx),
    .rd_data_o    (rd_data),
    .rd_iaddr_o   (rd_iaddr),
    .rd_force_o   (rd_force)
  );

  pcq_filter #(.AW(AW), .MW(MW), .BENIGN_MASK(BENIGN_MASK)) u_filter (
    .kind_i      (rd_kind),
    .iaddr_i     (rd_iaddr),
    .force_i     (rd_force),
    .exc_valid_i (exc_valid_q),
    .exc_fp_i    (exc_fp_q),
    .exc_mask_i  (exc_mask_q),
    .exc_iaddr_i (exc_iaddr_q),
    .br_taken_i  (br_taken_q),
    .apply_o     (flt_apply),
    .apply_reg_o (flt_apply_reg),
    .apply_pc_o  (flt_apply_pc)
  );

  // drain sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      rd_ptr_q   <= '0;
      br_taken_q <= 1'b0;
      new_pc_q   <= '0;
      save_pc_q  <= '0;
    end else if (cmt_go) begin
      state_q    <= S_RUN;
      rd_ptr_q   <= '0;
      br_taken_q <= 1'b0;
      save_pc_q  <= seq_pc_i;
    end else if (step) begin
      rd_ptr_q <= rd_ptr_q + CW'(1);
      if (flt_apply_pc) begin
        br_taken_q <= 1'b1;
        new_pc_q   <= rd_data[AW-1:0];
      end
    end else if (final_step) begin
      state_q  <= S_IDLE;
      rd_ptr_q <= '0;
    end
  end

  // packet state: exception record, link flag, overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_valid_q <= 1'b0;
      exc_fp_q    <= 1'b0;
      exc_mask_q  <= '0;
      exc_iaddr_q <= '0;
      link_q      <= 1'b0;
      ovf_q       <= 1'b0;
      prev_pc_q   <= RESET_PC;
    end else begin
      if (clr_go) begin
        exc_valid_q <= 1'b0;
        link_q      <= 1'b0;
        ovf_q       <= 1'b0;
        prev_pc_q   <= pc_q;
      end else begin
        if (exc_go) begin
          exc_valid_q <= 1'b1;
          exc_fp_q    <= exc_fp_i;
          exc_mask_q  <= exc_mask_i;
          exc_iaddr_q <= exc_iaddr_i;
        end
        if (link_go) link_q <= 1'b1;
        else if (final_step) link_q <= 1'b0;
        if (push_drop) ovf_q <= 1'b1;
      end
    end
  end

  // write ports and visible PC
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_we_q   <= 1'b0;
      rf_idx_q  <= '0;
      rf_data_q <= '0;
      lr_we_q   <= 1'b0;
      lr_data_q <= '0;
      done_q    <= 1'b0;
      pc_q      <= RESET_PC;
    end else begin
      rf_we_q <= step && flt_apply_reg;
      done_q  <= final_step;
      lr_we_q <= final_step && link_q;
      if (step && flt_apply_reg) begin
        rf_idx_q  <= rd_idx;
        rf_data_q <= rd_data;
      end
      if (final_step) lr_data_q <= save_pc_q;
      if (step && flt_apply) pc_q <= rd_iaddr;
      else if (final_step) pc_q <= br_taken_q ? new_pc_q : save_pc_q;
    end
  end

  // applied control-flow writes in the current drain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_apply_cnt <= '0;
    else if (cmt_go) pc_apply_cnt <= '0;
    else if (step && flt_apply_pc && pc_apply_cnt != 2'd3)
      pc_apply_cnt <= pc_apply_cnt + 2'd1;
  end

  assign rf_we_o   = rf_we_q;
  assign rf_idx_o  = rf_idx_q;
  assign rf_data_o = rf_data_q;
  assign lr_we_o   = lr_we_q;
  assign lr_data_o = lr_data_q;
  assign pc_o      = pc_q;
  assign prev_pc_o = prev_pc_q;
  assign busy_o    = (state_q == S_RUN);
  assign done_o    = done_q;
  assign ovf_o     = ovf_q;

  // R1
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && count == '0));

  // R2
  one_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_apply_cnt <= 2'd1);

  // R4
  fp_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && exc_valid_q && exc_fp_q && rd_iaddr == exc_iaddr_q &&
     (exc_mask_q & ~BENIGN_MASK) != '0) |=> !rf_we_o);

  // R5
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && exc_valid_q && !exc_fp_q && rd_iaddr == exc_iaddr_q && !rd_force)
      |=> !rf_we_o);

  // R7
  link_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_we_o |-> done_o);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !(clear_i && !busy_o)) |=> ovf_o);

  // R11
  rf_we_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> busy_o);

  // R11
  commit_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && !clear_i && !busy_o) |=> busy_o);
endmodule

// File: tb/pkt_commit_queue_tb.sv
module pkt_commit_queue_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 5, DW = 32, AW = 32, MW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enq_valid_i = 1'b0;
  logic [1:0]    enq_kind_i = '0;
  logic [IW-1:0] enq_idx_i = '0;
  logic [DW-1:0] enq_data_i = '0;
  logic [AW-1:0] enq_iaddr_i = '0;
  logic          enq_force_i = 1'b0;
  logic          exc_set_i = 1'b0;
  logic          exc_fp_i = 1'b0;
  logic [MW-1:0] exc_mask_i = '0;
  logic [AW-1:0] exc_iaddr_i = '0;
  logic          link_set_i = 1'b0;
  logic [AW-1:0] seq_pc_i = '0;
  logic          commit_i = 1'b0;
  logic          clear_i = 1'b0;
  logic          rf_we_o, lr_we_o, busy_o, done_o, ovf_o;
  logic [IW-1:0] rf_idx_o;
  logic [DW-1:0] rf_data_o;
  logic [AW-1:0] lr_data_o, pc_o, prev_pc_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_commit_queue u_dut (
    .clk(clk), .rst_n(rst_n),
    .enq_valid_i(enq_valid_i), .enq_kind_i(enq_kind_i), .enq_idx_i(enq_idx_i),
    .enq_data_i(enq_data_i), .enq_iaddr_i(enq_iaddr_i), .enq_force_i(enq_force_i),
    .exc_set_i(exc_set_i), .exc_fp_i(exc_fp_i), .exc_mask_i(exc_mask_i),
    .exc_iaddr_i(exc_iaddr_i), .link_set_i(link_set_i), .seq_pc_i(seq_pc_i),
    .commit_i(commit_i), .clear_i(clear_i),
    .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o),
    .lr_we_o(lr_we_o), .lr_data_o(lr_data_o), .pc_o(pc_o), .prev_pc_o(prev_pc_o),
    .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  // row: kind[72:71] idx[70:66] data[65:34] iaddr[33:2] force[1] expect_apply[0]
  localparam logic [72:0] VEC [8] = '{
    {2'd0, 5'd1, 32'h0000_00A1, 32'h0000_0100, 1'b0, 1'b0},
    {2'd0, 5'd2, 32'h0000_00A2, 32'h0000_0100, 1'b1, 1'b1},
    {2'd1, 5'd0, 32'h0000_0500, 32'h0000_0100, 1'b0, 1'b0},
    {2'd0, 5'd3, 32'h0000_00A3, 32'h0000_0104, 1'b0, 1'b1},
    {2'd1, 5'd0, 32'h0000_0600, 32'h0000_0104, 1'b0, 1'b1},
    {2'd2, 5'd0, 32'h0000_0700, 32'h0000_0108, 1'b0, 1'b0},
    {2'd0, 5'd4, 32'h0000_00A4, 32'h0000_0108, 1'b0, 1'b1},
    {2'd0, 5'd5, 32'h0000_00A5, 32'h0000_010C, 1'b0, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic enq(input logic [1:0] k, input logic [IW-1:0] i, input logic [DW-1:0] d,
                     input logic [AW-1:0] a, input logic f);
    enq_valid_i = 1'b1; enq_kind_i = k; enq_idx_i = i; enq_data_i = d;
    enq_iaddr_i = a; enq_force_i = f;
    tick();
    enq_valid_i = 1'b0;
  endtask

  task automatic set_exc(input logic fp, input logic [MW-1:0] m, input logic [AW-1:0] a);
    exc_set_i = 1'b1; exc_fp_i = fp; exc_mask_i = m; exc_iaddr_i = a;
    tick();
    exc_set_i = 1'b0;
  endtask

  task automatic pulse_commit();
    commit_i = 1'b1;
    tick();
    commit_i = 1'b0;
  endtask

  task automatic pulse_clear();
    clear_i = 1'b1;
    tick();
    clear_i = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [IW-1:0] i,
                            input logic [DW-1:0] d, input logic [AW-1:0] a);
    check(rf_we_o && rf_idx_o == i && rf_data_o == d, req,
          {27'd0, rf_we_o, rf_idx_o, rf_data_o}, {27'd0, 1'b1, i, d});
    check(pc_o == a, req, 64'(pc_o), 64'(a));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] exp_pc;
    tick();
    tick();
    rst_n = 1'b1;
    tick();
    // R12 reset state
    check(!busy_o && !done_o && !ovf_o && !rf_we_o && !lr_we_o, "R12",
          {59'd0, busy_o, done_o, ovf_o, rf_we_o, lr_we_o}, 64'd0);
    check(pc_o == '0 && prev_pc_o == '0, "R12", 64'(pc_o), 64'd0);

    // table packet: non-FP exception at 0x100, two branches, full queue
    set_exc(1'b0, 8'h00, 32'h100);
    for (int r = 0; r < 8; r++)
      enq(VEC[r][72:71], VEC[r][70:66], VEC[r][65:34], VEC[r][33:2], VEC[r][1]);
    enq(2'd0, 5'd9, 32'hDEAD, 32'h110, 1'b1);
    check(ovf_o == 1'b1, "R9", 64'(ovf_o), 64'd1);
    seq_pc_i = 32'h200;
    pulse_commit();
    exp_pc = '0;
    for (int r = 0; r < 8; r++) begin
      tick();
      if (VEC[r][0]) exp_pc = VEC[r][33:2];
      if (VEC[r][0] && VEC[r][72:71] == 2'd0) begin
        expect_reg("R1 R3 R5", VEC[r][70:66], VEC[r][65:34], VEC[r][33:2]);
      end else begin
        check(!rf_we_o, "R2 R5", 64'(rf_we_o), 64'd0);
        check(pc_o == exp_pc, "R6", 64'(pc_o), 64'(exp_pc));
      end
      check(!done_o, "R1", 64'(done_o), 64'd0);
    end
    tick();
    check(done_o && !busy_o, "R1", {62'd0, done_o, busy_o}, 64'd2);
    check(pc_o == 32'h600, "R2 R6", 64'(pc_o), 64'h600);
    check(!lr_we_o, "R7", 64'(lr_we_o), 64'd0);
    tick();
    check(!done_o, "R1", 64'(done_o), 64'd0);
    check(ovf_o == 1'b1, "R9", 64'(ovf_o), 64'd1);

    // FP benign mask, reserved kind, link update
    pulse_clear();
    check(!ovf_o && prev_pc_o == 32'h600, "R8", {31'd0, ovf_o, prev_pc_o},
          {32'd0, 32'h600});
    set_exc(1'b1, 8'h05, 32'h200);
    enq(2'd0, 5'd6, 32'h66, 32'h200, 1'b0);
    enq(2'd3, 5'd7, 32'h77, 32'h204, 1'b1);
    link_set_i = 1'b1; tick(); link_set_i = 1'b0;
    seq_pc_i = 32'h300;
    pulse_commit();
    tick();
    expect_reg("R4", 5'd6, 32'h66, 32'h200);
    tick();
    check(!rf_we_o && pc_o == 32'h200, "R10", {31'd0, rf_we_o, pc_o},
          {32'd0, 32'h200});
    tick();
    check(done_o && pc_o == 32'h300, "R6", {31'd0, done_o, pc_o}, {32'd1, 32'h300});
    check(lr_we_o && lr_data_o == 32'h300, "R7", {31'd0, lr_we_o, lr_data_o},
          {32'd1, 32'h300});

    // FP harmful mask drops faulting writes including its branch
    pulse_clear();
    set_exc(1'b1, 8'h08, 32'h400);
    enq(2'd0, 5'd8, 32'h88, 32'h400, 1'b1);
    enq(2'd1, 5'd0, 32'h900, 32'h400, 1'b0);
    enq(2'd0, 5'd9, 32'h99, 32'h404, 1'b0);
    seq_pc_i = 32'h500;
    commit_i = 1'b1; tick(); commit_i = 1'b0;
    enq_valid_i = 1'b1; enq_kind_i = 2'd0; enq_idx_i = 5'd10; enq_data_i = 32'hAA;
    enq_iaddr_i = 32'h408;
    tick();
    enq_valid_i = 1'b0;
    check(!rf_we_o, "R4", 64'(rf_we_o), 64'd0);
    tick();
    check(!rf_we_o && pc_o == 32'h300, "R4 R2", {31'd0, rf_we_o, pc_o},
          {32'd0, 32'h300});
    tick();
    expect_reg("R3", 5'd9, 32'h99, 32'h404);
    tick();
    check(done_o && pc_o == 32'h500, "R2 R6", {31'd0, done_o, pc_o},
          {32'd1, 32'h500});
    check(!lr_we_o, "R7", 64'(lr_we_o), 64'd0);

    // the enqueue made while busy left nothing behind
    pulse_commit();
    tick();
    check(done_o && !rf_we_o, "R11", {62'd0, done_o, rf_we_o}, 64'd2);

    // clear discards posted entries
    tick();
    enq(2'd0, 5'd11, 32'hBB, 32'h600, 1'b0);
    enq(2'd1, 5'd0, 32'hC00, 32'h604, 1'b0);
    pulse_clear();
    check(prev_pc_o == 32'h500, "R8", 64'(prev_pc_o), 64'h500);
    seq_pc_i = 32'h700;
    pulse_commit();
    check(!rf_we_o && !done_o, "R8", {62'd0, rf_we_o, done_o}, 64'd0);
    tick();
    check(done_o && pc_o == 32'h700, "R8 R1", {31'd0, done_o, pc_o},
          {32'd1, 32'h700});

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule